// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of a single bus function. A requester presents one access per cycle: a byte offset, a width (one, two or four bytes) and, for a write, the data. Multi-byte data is little-endian. The byte at offset `reqAddr + k` sits in bits `[8k +: 8]` of the data word. Reads return their data one cycle after the request. Writes take effect at the next clock edge.

The block enforces the write rules of a configuration header. Identifier, class and header-type bytes are fixed at reset from parameters and cannot be written. The set of protected bytes depends on the header type stored at offset 0x0E. A four-byte write to a base-address register of a region with nonzero size is stored with the address size-aligned; the region's type bits are forced into memory and I/O registers, and the enable bit is kept for the expansion-ROM register. Reserved status bits always read as zero. A write that touches the command register raises a one-cycle pulse, so that the system can rebuild its address decode.

Top module: `cfg_space`

## Requirements
- R1: After reset the identifier bytes hold their parameter values: vendor at 0x00–0x01, device at 0x02–0x03, revision at 0x08, class code at 0x09–0x0B (programming interface, sub-class, base class) and header type at 0x0E. Byte 0x10+4r holds the type bits of each region r of nonzero size. Every other byte is zero.
- R2: A read request with `reqLen` 0 (one byte), 1 (two bytes) or 2/3 (four bytes) returns little-endian, zero-extended data on `rdData` with `rdValid` high in the cycle after the request.
- R3: A four-byte read at an offset above 0xFC returns two bytes. A two-byte read (requested or fallen back) at offset 0xFF returns one byte.
- R4: Other writes update bytes `reqAddr+k` one by one at the next edge. Bytes past offset 0xFF are dropped, and no write wraps to offset 0x00.
- R5: With header type 0x00 or 0x80, writes to 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x2C–0x33 and 0x3D leave those bytes unchanged.
- R6: With any other header type, writes to 0x00–0x03, 0x08–0x0B, 0x0E, 0x2C–0x2F, 0x38–0x3B and 0x3D leave those bytes unchanged. Bytes 0x10–0x27 and 0x30–0x33 are writable.
- R7: A four-byte write at an offset in 0x10–0x27 selects region (offset−0x10)/4. If that region's size is nonzero, the block stores `data & ~(size−1)` with the region's type bits ORed in. The four bytes are written from the offset without regard to protection.
- R8: A four-byte write at 0x30–0x33 with a nonzero ROM size stores `data & ~(size−1)` with data bit 0 (the ROM enable) kept.
- R9: A four-byte write to a region register whose region size is zero follows the ordinary byte rules of R4–R6.
- R10: Status bits marked reserved by parameter (offset 0x06 low mask, offset 0x07 high mask) are written as zero.
- R11: `cmdUpdate` pulses high for one cycle after a write on the ordinary byte path whose byte range overlaps offsets 0x04–0x05. This applies even if no byte changes. Reads and base-address writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Starting byte offset |
| reqLen | input | 2 | Width: 0 byte, 1 two bytes, 2/3 four bytes |
| wrData | input | 32 | Little-endian write data |
| rdValid | output | 1 | Read data valid (cycle after the read request) |
| rdData | output | 32 | Little-endian, zero-extended read data |
| cmdUpdate | output | 1 | One-cycle pulse after a command-register write |

## Verification
The bench targets several corner cases, each with a distinct symptom if the design gets it wrong:
- Accesses at the top of the space: a design without read fallback would return bytes from a wrapped offset, and one without write truncation would touch offset 0x00 or 0x01.
- The two protection maps, checked side by side on a type-0 and a type-1 instance: a wrong map shows up as a bridge base register that cannot be written, or as an endpoint identifier that changes.
- Base-address writes of all-ones: these expose a missing size mask, a lost type bit or a cleared ROM enable.
- Zero-size regions: these must fall back to the byte rules.
- Boundaries of the command-overlap window (offsets 0x03, 0x05, 0x06 and a four-byte write at 0x02): these catch an off-by-one in the update pulse.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int NUM_BARS = 6;
  localparam int ROM_IDX  = 6;

  typedef struct packed {
    logic       wrBar;    // size-masked base-address write
    logic [2:0] barIdx;   // selected region, ROM_IDX for the ROM register
    logic [3:0] laneWe;   // byte lane k writes offset reqAddr+k
    logic       cmdHit;   // ordinary write overlapping the command bytes
    logic       rdEn;     // read request
    logic [1:0] rdBytes;  // 0: one byte, 1: two bytes, 2: four bytes
  } cfgStrobe_t;

  // Write protection per byte, selected by the header type byte
  function automatic logic isLocked(input logic [7:0] a, input logic [7:0] hdr);
    logic common;
    logic extra;
    common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E) ||
             (a >= 8'h2C && a <= 8'h2F) || (a == 8'h3D);
    if (hdr == 8'h00 || hdr == 8'h80)
      extra = (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    else
      extra = (a >= 8'h38 && a <= 8'h3B);
    return common || extra;
  endfunction

endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
#(
  parameter logic [6:0][31:0] REGION_SIZE = '0
) (
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [7:0] reqAddr,
  input  logic [1:0] reqLen,
  input  logic [7:0] hdrType,
  output cfgStrobe_t strobe
);

  logic [2:0] nBytes;
  logic [8:0] endAddr;
  logic [7:0] barOff;
  logic       inBar;
  logic       inRom;
  logic       isWr;
  logic       isDword;

  always_comb begin
    case (reqLen)
      2'd0:    nBytes = 3'd1;
      2'd1:    nBytes = 3'd2;
      default: nBytes = 3'd4;
    endcase
    isDword = reqLen[1];
    isWr    = reqValid && reqWrite;
    endAddr = {1'b0, reqAddr} + {6'b0, nBytes};
    barOff  = reqAddr - 8'h10;
    inBar   = (reqAddr >= 8'h10) && (reqAddr <= 8'h27);
    inRom   = (reqAddr[7:2] == 6'b001100);
  end

  always_comb begin
    strobe        = '0;
    strobe.barIdx = inRom ? 3'(ROM_IDX) : barOff[4:2];
    strobe.wrBar  = isWr && isDword && (inBar || inRom) &&
                    (REGION_SIZE[strobe.barIdx] != 32'd0);
    for (int k = 0; k < 4; k++) begin
      logic [8:0] laneAddr;
      laneAddr = {1'b0, reqAddr} + 9'(k);
      strobe.laneWe[k] = isWr && (3'(k) < nBytes) && !laneAddr[8] &&
                         (strobe.wrBar || !isLocked(laneAddr[7:0], hdrType));
    end
    strobe.cmdHit = isWr && !strobe.wrBar && (endAddr > 9'd4) && (reqAddr < 8'd6);
    strobe.rdEn   = reqValid && !reqWrite;
    if (isDword && reqAddr <= 8'hFC)
      strobe.rdBytes = 2'd2;
    else if (reqLen != 2'd0 && reqAddr <= 8'hFE)
      strobe.rdBytes = 2'd1;
    else
      strobe.rdBytes = 2'd0;
  end

endmodule

// File: rtl/cfg_space_dp.sv
module cfg_space_dp
  import cfg_space_pkg::*;
#(
  parameter logic [15:0]      VENDOR_ID   = 16'h0,
  parameter logic [15:0]      DEVICE_ID   = 16'h0,
  parameter logic [7:0]       REVISION    = 8'h0,
  parameter logic [23:0]      CLASS_CODE  = 24'h0,
  parameter logic [7:0]       HEADER_TYPE = 8'h0,
  parameter logic [6:0][31:0] REGION_SIZE = '0,
  parameter logic [5:0][7:0]  REGION_TYPE = '0,
  parameter logic [7:0]       STAT_RSV_LO = 8'h0F,
  parameter logic [7:0]       STAT_RSV_HI = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strobe,
  input  logic [7:0]  reqAddr,
  input  logic [31:0] wrData,
  output logic [7:0]  hdrType,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        cmdUpdate
);

  localparam int SPACE_BYTES = 256;

  logic [7:0]  cfgMem [SPACE_BYTES];
  logic [31:0] barVal;
  logic [7:0]  laneData [4];
  logic [7:0]  laneIdx  [4];

  function automatic logic [7:0] resetByte(input int idx);
    logic [7:0] v;
    case (idx)
      8'h00:   v = VENDOR_ID[7:0];
      8'h01:   v = VENDOR_ID[15:8];
      8'h02:   v = DEVICE_ID[7:0];
      8'h03:   v = DEVICE_ID[15:8];
      8'h08:   v = REVISION;
      8'h09:   v = CLASS_CODE[7:0];
      8'h0A:   v = CLASS_CODE[15:8];
      8'h0B:   v = CLASS_CODE[23:16];
      8'h0E:   v = HEADER_TYPE;
      default: v = 8'h00;
    endcase
    for (int r = 0; r < NUM_BARS; r++)
      if (idx == 16 + 4 * r && REGION_SIZE[r] != 32'd0) v = REGION_TYPE[r];
    return v;
  endfunction

  always_comb begin
    logic [31:0] keep;
    keep = ~(REGION_SIZE[strobe.barIdx] - 32'd1);
    if (strobe.barIdx == 3'(ROM_IDX))
      barVal = (wrData & keep) | {31'b0, wrData[0]};
    else
      barVal = (wrData & keep) | {24'b0, REGION_TYPE[strobe.barIdx]};
    for (int k = 0; k < 4; k++) begin
      laneIdx[k] = reqAddr + 8'(k);
      if (strobe.wrBar)
        laneData[k] = barVal[8*k +: 8];
      else if (laneIdx[k] == 8'h06)
        laneData[k] = wrData[8*k +: 8] & ~STAT_RSV_LO;
      else if (laneIdx[k] == 8'h07)
        laneData[k] = wrData[8*k +: 8] & ~STAT_RSV_HI;
      else
        laneData[k] = wrData[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SPACE_BYTES; i++) cfgMem[i] <= resetByte(i);
    end else begin
      for (int k = 0; k < 4; k++)
        if (strobe.laneWe[k]) cfgMem[laneIdx[k]] <= laneData[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdData    <= '0;
      cmdUpdate <= 1'b0;
    end else begin
      rdValid   <= strobe.rdEn;
      cmdUpdate <= strobe.cmdHit;
      if (strobe.rdEn)
        rdData <= {(strobe.rdBytes == 2'd2) ? cfgMem[laneIdx[3]] : 8'h00,
                   (strobe.rdBytes == 2'd2) ? cfgMem[laneIdx[2]] : 8'h00,
                   (strobe.rdBytes != 2'd0) ? cfgMem[laneIdx[1]] : 8'h00,
                   cfgMem[laneIdx[0]]};
    end
  end

  assign hdrType = cfgMem[8'h0E];

  // R5 R6
  id_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgMem[8'h00]) && $stable(cfgMem[8'h0E]));

  // R10
  status_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgMem[8'h06] & STAT_RSV_LO) == 8'h00) && ((cfgMem[8'h07] & STAT_RSV_HI) == 8'h00));

  // R2
  byte_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(strobe.rdBytes == 2'd0) |-> rdData[31:8] == 24'h0);

endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_space_pkg::*;
#(
  parameter logic [15:0]      VENDOR_ID   = 16'h1B36,
  parameter logic [15:0]      DEVICE_ID   = 16'h0010,
  parameter logic [7:0]       REVISION    = 8'h02,
  parameter logic [23:0]      CLASS_CODE  = 24'h020000,
  parameter logic [7:0]       HEADER_TYPE = 8'h00,
  parameter logic [6:0][31:0] REGION_SIZE = {32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'h0,
                                             32'h0000_0020, 32'h0000_1000},
  parameter logic [5:0][7:0]  REGION_TYPE = {8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00},
  parameter logic [7:0]       STAT_RSV_LO = 8'h0F,
  parameter logic [7:0]       STAT_RSV_HI = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [7:0]  reqAddr,
  input  logic [1:0]  reqLen,
  input  logic [31:0] wrData,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        cmdUpdate
);

  cfgStrobe_t strobe;
  logic [7:0] hdrType;

  cfg_space_ctrl #(.REGION_SIZE(REGION_SIZE)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .hdrType  (hdrType),
    .strobe   (strobe)
  );

  cfg_space_dp #(
    .VENDOR_ID   (VENDOR_ID),
    .DEVICE_ID   (DEVICE_ID),
    .REVISION    (REVISION),
    .CLASS_CODE  (CLASS_CODE),
    .HEADER_TYPE (HEADER_TYPE),
    .REGION_SIZE (REGION_SIZE),
    .REGION_TYPE (REGION_TYPE),
    .STAT_RSV_LO (STAT_RSV_LO),
    .STAT_RSV_HI (STAT_RSV_HI)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .wrData    (wrData),
    .hdrType   (hdrType),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .cmdUpdate (cmdUpdate)
  );

  // R2
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rdValid);

  // R11
  cmd_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdUpdate |-> $past(reqValid && reqWrite));

endmodule

// File: tb/test_cfg_space.sv
module test_cfg_space;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [1:0]  reqLen = '0;
  logic [31:0] wrData = '0;
  logic        rdValidA, rdValidB, cmdA, cmdB;
  logic [31:0] rdDataA, rdDataB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_space i_cfg_space (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData),
    .rdValid(rdValidA), .rdData(rdDataA), .cmdUpdate(cmdA)
  );

  cfg_space #(
    .VENDOR_ID(16'h8086), .DEVICE_ID(16'h2448), .REVISION(8'h11),
    .CLASS_CODE(24'h060400), .HEADER_TYPE(8'h01),
    .REGION_SIZE({32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0100}),
    .REGION_TYPE({8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h08})
  ) i_cfg_space_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData),
    .rdValid(rdValidB), .rdData(rdDataB), .cmdUpdate(cmdB)
  );

  // Bench model of both instances
  logic [7:0]  mdl [2][256];
  logic [31:0] bSize [2][7];
  logic [7:0]  bType [2][6];
  logic [7:0]  hdrM [2];

  function automatic bit mLocked(int a, logic [7:0] hdr);
    if (a inside {[0:3], [8:11], 14, [44:47], 61}) return 1;
    if (hdr == 8'h00 || hdr == 8'h80) return a inside {[16:39], [48:51]};
    return a inside {[56:59]};
  endfunction

  task automatic mReset(int w, logic [15:0] ven, logic [15:0] dev, logic [7:0] rev,
                        logic [23:0] cls, logic [7:0] hdr);
    for (int i = 0; i < 256; i++) mdl[w][i] = 8'h00;
    mdl[w][0] = ven[7:0];  mdl[w][1] = ven[15:8];
    mdl[w][2] = dev[7:0];  mdl[w][3] = dev[15:8];
    mdl[w][8] = rev;
    mdl[w][9] = cls[7:0];  mdl[w][10] = cls[15:8]; mdl[w][11] = cls[23:16];
    mdl[w][14] = hdr;
    hdrM[w] = hdr;
    for (int r = 0; r < 6; r++) if (bSize[w][r] != 0) mdl[w][16 + 4 * r] = bType[w][r];
  endtask

  function automatic logic [31:0] mRead(int w, int a, int lc);
    int n;
    logic [31:0] v;
    n = (lc == 0) ? 1 : (lc == 1) ? 2 : 4;
    if (n == 4 && a > 252) n = 2;
    if (n == 2 && a > 254) n = 1;
    v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = mdl[w][a + k];
    return v;
  endfunction

  task automatic mWrite(int w, int a, logic [31:0] d, int lc, output bit cmd);
    int n;
    int r;
    logic [31:0] v;
    logic [7:0] b;
    n = (lc == 0) ? 1 : (lc == 1) ? 2 : 4;
    cmd = 0;
    if (n == 4 && ((a >= 16 && a < 40) || (a >= 48 && a < 52))) begin
      r = (a >= 48) ? 6 : (a - 16) / 4;
      if (bSize[w][r] != 0) begin
        v = d & ~(bSize[w][r] - 1);
        if (r == 6) v = v | (d & 32'h1);
        else v = v | {24'h0, bType[w][r]};
        for (int k = 0; k < 4; k++) mdl[w][a + k] = v[8*k +: 8];
        return;
      end
    end
    for (int k = 0; k < n; k++) begin
      if (a + k <= 255 && !mLocked(a + k, hdrM[w])) begin
        b = d[8*k +: 8];
        if (a + k == 6) b = b & 8'hF0;
        mdl[w][a + k] = b;
      end
    end
    cmd = (a + n > 4) && (a < 6);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doOp(bit wr, int a, int lc, logic [31:0] d, string tag);
    logic [31:0] expR [2];
    bit expC [2];
    for (int w = 0; w < 2; w++) begin
      expC[w] = 0;
      expR[w] = '0;
      if (wr) mWrite(w, a, d, lc, expC[w]);
      else expR[w] = mRead(w, a, lc);
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = 8'(a); reqLen = 2'(lc); wrData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) begin
      check(tag, 32'(cmdA), 32'(expC[0]), $sformatf("cmdUpdate type0 @%0h", a));
      check(tag, 32'(cmdB), 32'(expC[1]), $sformatf("cmdUpdate type1 @%0h", a));
    end else begin
      check(tag, 32'(rdValidA), 32'h1, "rdValid type0");
      check(tag, rdDataA, expR[0], $sformatf("rdData type0 @%0h len%0d", a, lc));
      check(tag, 32'(rdValidB), 32'h1, "rdValid type1");
      check(tag, rdDataB, expR[1], $sformatf("rdData type1 @%0h len%0d", a, lc));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd4242);
    for (int w = 0; w < 2; w++) for (int r = 0; r < 7; r++) bSize[w][r] = 0;
    for (int w = 0; w < 2; w++) for (int r = 0; r < 6; r++) bType[w][r] = 0;
    bSize[0][0] = 32'h1000; bSize[0][1] = 32'h20; bType[0][1] = 8'h01; bSize[0][6] = 32'h10000;
    bSize[1][0] = 32'h100;  bType[1][0] = 8'h08;
    mReset(0, 16'h1B36, 16'h0010, 8'h02, 24'h020000, 8'h00);
    mReset(1, 16'h8086, 16'h2448, 8'h11, 24'h060400, 8'h01);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R2", 32'(rdValidA), 32'h0, "rdValid idle after reset");
    check("R11", 32'(cmdA), 32'h0, "cmdUpdate idle after reset");

    // R1: reset image, byte by byte
    for (int a = 0; a < 256; a++) doOp(0, a, 0, '0, "R1");
    // R2: widths and byte order
    doOp(0, 0, 2, '0, "R2");
    doOp(0, 0, 3, '0, "R2");
    doOp(0, 8, 1, '0, "R2");
    doOp(0, 9, 2, '0, "R2");

    // R3: top-of-space reads
    doOp(1, 8'hFC, 2, 32'h44332211, "R4");
    doOp(0, 8'hFD, 2, '0, "R3");
    doOp(0, 8'hFF, 2, '0, "R3");
    doOp(0, 8'hFF, 1, '0, "R3");
    doOp(0, 8'hFE, 1, '0, "R3");
    doOp(0, 8'hFC, 3, '0, "R3");

    // R4: truncation at 0xFF, narrow writes
    doOp(1, 8'hFE, 2, 32'hAABBCCDD, "R4");
    doOp(0, 8'hFC, 2, '0, "R4");
    doOp(0, 0, 2, '0, "R4");
    doOp(1, 8'h40, 0, 32'hFFFFFF5A, "R4");
    doOp(1, 8'h41, 1, 32'h99887766, "R4");
    doOp(0, 8'h40, 2, '0, "R4");

    // R7: size masking and type bits
    doOp(1, 8'h10, 2, 32'hFFFFFFFF, "R7");
    doOp(0, 8'h10, 2, '0, "R7");
    doOp(1, 8'h14, 2, 32'hFFFFFFFF, "R7");
    doOp(0, 8'h14, 2, '0, "R7");
    doOp(1, 8'h10, 2, 32'h1234_5678, "R7");
    doOp(0, 8'h10, 2, '0, "R7");

    // R8: ROM register keeps its enable bit
    doOp(1, 8'h30, 2, 32'hFFFFFFFF, "R8");
    doOp(0, 8'h30, 2, '0, "R8");
    doOp(1, 8'h30, 2, 32'h12345678, "R8");
    doOp(0, 8'h30, 2, '0, "R8");

    // R5 / R6: protection maps
    doOp(1, 8'h00, 2, 32'hFFFFFFFF, "R5");
    doOp(1, 8'h08, 2, 32'hFFFFFFFF, "R5");
    doOp(1, 8'h0C, 2, 32'hFFFFFFFF, "R5");
    doOp(1, 8'h11, 0, 32'h000000AB, "R5");
    doOp(1, 8'h2C, 2, 32'hCAFEF00D, "R5");
    doOp(1, 8'h3C, 1, 32'h0000FFFF, "R5");
    doOp(1, 8'h38, 2, 32'h01020304, "R6");
    doOp(1, 8'h31, 0, 32'h00000077, "R6");
    for (int a = 0; a < 64; a += 4) doOp(0, a, 2, '0, "R6");

    // R9: zero-size regions use the byte rules
    doOp(1, 8'h18, 2, 32'hDEADBEEF, "R9");
    doOp(1, 8'h14, 3, 32'hDEADBEEF, "R9");
    doOp(0, 8'h18, 2, '0, "R9");
    doOp(0, 8'h14, 2, '0, "R9");

    // R10: reserved status bits
    doOp(1, 8'h06, 1, 32'h0000FFFF, "R10");
    doOp(0, 8'h06, 1, '0, "R10");
    doOp(1, 8'h05, 2, 32'hFFFFFFFF, "R10");
    doOp(0, 8'h04, 2, '0, "R10");

    // R11: command overlap window edges
    doOp(1, 8'h04, 1, 32'h00000007, "R11");
    doOp(1, 8'h03, 0, 32'h00000000, "R11");
    doOp(1, 8'h02, 2, 32'h00050000, "R11");
    doOp(1, 8'h05, 0, 32'h00000001, "R11");
    doOp(1, 8'h06, 0, 32'h00000000, "R11");
    doOp(1, 8'h01, 2, 32'h00000000, "R11");
    doOp(1, 8'h00, 1, 32'h00000000, "R11");

    // Constrained random traffic
    for (int i = 0; i < 800; i++) begin
      int unsigned a;
      int unsigned lc;
      bit wr;
      a  = ($urandom % 2 == 0) ? ($urandom % 64) : ($urandom % 256);
      lc = $urandom % 4;
      wr = ($urandom % 2) == 1;
      if (wr) doOp(1, int'(a), int'(lc), $urandom, "R11");
      else    doOp(0, int'(a), int'(lc), '0, "R2");
    end

    // Final image
    for (int a = 0; a < 256; a++) doOp(0, a, 0, '0, "R4");

    summary();
  end

endmodule